// File: doc/BRIEF.md
# Edge-Counting Frequency Divider

This block is one timer channel used as a frequency divider. A signal arrives on an asynchronous input pin. The block brings it into the system clock domain and picks out the edges that software has marked as valid: falling only, rising only, or both. Those edges drive a reloading down-counter instead of the system clock. Each time the counter finishes an interval, the block sends out a one-cycle interrupt pulse. If counter control of the output pin is enabled, the output pin also flips at that moment, so the pin carries the input rate divided by a programmable amount.

Software starts and stops counting with one-cycle command pulses. A start-behaviour bit decides whether the start itself raises the interrupt and flips the output. A level-write strobe sets the output pin directly, but only while counter control of the output is disabled. The output keeps normal polarity and has no inversion stage.

Top module: `edge_divider`

## Requirements
- R1: After synchronous reset the channel is idle, `irq` is 0 and `pin_out` is 0.
- R2: `cfg_edge_sel` selects the valid input edges: 2'b00 counts falling edges only, 2'b01 counts rising edges only, 2'b10 counts both edges. Edges of the other kind have no effect.
- R3: With `cfg_edge_sel` = 2'b11 no edge counts. `irq` stays 0 and `pin_out` keeps its level while the input toggles.
- R4: After a start with `reload_val` = N, the counter reloads and `irq` pulses for one cycle on every (N+1)-th valid edge. With `cfg_out_en` = 1, `pin_out` flips in the same cycle, so the output period is 2*(N+1) valid edges.
- R5: When `start` is sampled with `cfg_start_irq` = 1, `irq` is high in the next cycle and `pin_out` flips if `cfg_out_en` = 1. With `cfg_start_irq` = 0, the start raises no pulse and does not change the pin.
- R6: While `cfg_out_en` = 0, counting never changes `pin_out`, but `irq` still pulses on each interval.
- R7: A `level_wr` strobe with `cfg_out_en` = 0 sets `pin_out` to `level_data` in the next cycle. With `cfg_out_en` = 1 the strobe is ignored.
- R8: `stop` halts counting: no further `irq` pulses, and `pin_out` holds its level. A later `start` reloads N and applies the R5 rule again.
- R9: A pin transition reaches `irq`/`pin_out` on the third rising clock edge after it: two synchroniser flops, then the registered result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external count input |
| cfg_edge_sel | input | 2 | Valid-edge select (00 fall, 01 rise, 10 both, 11 none) |
| cfg_start_irq | input | 1 | Start raises irq and flips the output when 1 |
| cfg_out_en | input | 1 | Counter control of the output pin enabled |
| level_wr | input | 1 | Direct output level write strobe |
| level_data | input | 1 | Level written by `level_wr` |
| reload_val | input | CNT_W | Interval reload value N |
| start | input | 1 | Start/restart command pulse |
| stop | input | 1 | Stop command pulse |
| irq | output | 1 | One-cycle interval interrupt pulse |
| pin_out | output | 1 | Divided output pin |

## Verification
The bench builds the channel with `CNT_W` = 4. At that width the largest reload value, 15, fits in a few dozen input transitions, so every edge mode meets both the smallest interval (N = 0, one pulse per valid edge) and the wrap at the counter maximum. With such short intervals, the bench can sweep all four edge-select codes against several reload values and both start behaviours, predicting every pulse from a count of valid edges modulo N+1.

// File: rtl/edge_div_pkg.sv
package edge_div_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_pair_t;

    typedef struct packed {
        logic start_evt;
        logic wrap_evt;
    } div_evt_t;

    localparam int SYNC_STAGES = 2;

    function automatic logic edge_valid(edge_sel_e sel, edge_pair_t e);
        case (sel)
            EDGE_FALL: edge_valid = e.fall;
            EDGE_RISE: edge_valid = e.rise;
            EDGE_BOTH: edge_valid = e.rise | e.fall;
            default:   edge_valid = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/edge_div_detect.sv
module edge_div_detect
    import edge_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_in,
    input  edge_sel_e sel,
    output logic      hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    edge_pair_t             edges;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[i] <= 1'b0;
                    else     sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[SYNC_STAGES-1];
    end

    always_comb begin
        edges.rise = sync_q[SYNC_STAGES-1] & ~prev_q;
        edges.fall = ~sync_q[SYNC_STAGES-1] & prev_q;
        hit        = edge_valid(sel, edges);
    end
endmodule

// File: rtl/edge_div_counter.sv
module edge_div_counter
    import edge_div_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             stop,
    input  logic             start_irq,
    input  logic             hit,
    input  logic [CNT_W-1:0] reload,
    output logic             toggle,
    output logic             irq,
    output logic             run
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic             irq_q;
    logic             counting;
    div_evt_t         evt;

    always_comb begin
        counting      = run_q & ~start & ~stop & hit;
        evt.start_evt = start & start_irq;
        evt.wrap_evt  = counting & (cnt_q == CNT_ZERO);
        toggle        = evt.start_evt | evt.wrap_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_ZERO;
            run_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= toggle;
            if (start) begin
                run_q <= 1'b1;
                cnt_q <= reload;
            end else if (stop) begin
                run_q <= 1'b0;
            end else if (counting) begin
                if (cnt_q == CNT_ZERO) cnt_q <= reload;
                else                   cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    assign irq = irq_q;
    assign run = run_q;
endmodule

// File: rtl/edge_div_outctl.sv
module edge_div_outctl (
    input  logic clk,
    input  logic rst,
    input  logic out_en,
    input  logic toggle,
    input  logic lvl_wr,
    input  logic lvl_data,
    output logic pin
);
    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else if (out_en) begin
            if (toggle) pin_q <= ~pin_q;
        end else if (lvl_wr) begin
            pin_q <= lvl_data;
        end
    end

    assign pin = pin_q;
endmodule

// File: rtl/edge_divider.sv
module edge_divider
    import edge_div_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pin_in,
    input  logic [1:0]       cfg_edge_sel,
    input  logic             cfg_start_irq,
    input  logic             cfg_out_en,
    input  logic             level_wr,
    input  logic             level_data,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             start,
    input  logic             stop,
    output logic             irq,
    output logic             pin_out
);
    logic      hit_w;
    logic      toggle_w;
    logic      run_w;
    edge_sel_e sel_w;

    assign sel_w = edge_sel_e'(cfg_edge_sel);

    edge_div_detect u_det (
        .clk    (clk),
        .rst    (rst),
        .pin_in (pin_in),
        .sel    (sel_w),
        .hit    (hit_w)
    );

    edge_div_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .stop      (stop),
        .start_irq (cfg_start_irq),
        .hit       (hit_w),
        .reload    (reload_val),
        .toggle    (toggle_w),
        .irq       (irq),
        .run       (run_w)
    );

    edge_div_outctl u_out (
        .clk      (clk),
        .rst      (rst),
        .out_en   (cfg_out_en),
        .toggle   (toggle_w),
        .lvl_wr   (level_wr),
        .lvl_data (level_data),
        .pin      (pin_out)
    );
endmodule

// File: rtl/edge_divider_chk.sv
module edge_divider_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] cfg_edge_sel,
    input logic       cfg_out_en,
    input logic       level_wr,
    input logic       start,
    input logic       run,
    input logic       hit,
    input logic       irq,
    input logic       pin_out
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && !pin_out));

    assert_none_code_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_edge_sel == 2'b11) |-> !hit);

    assert_toggle_with_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (irq && $past(cfg_out_en)) |-> (pin_out != $past(pin_out)));

    assert_disabled_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(cfg_out_en) && !$past(level_wr)) |-> $stable(pin_out));

    assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_out_en) && !irq) |-> $stable(pin_out));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(start)) |-> !irq);
endmodule

bind edge_divider edge_divider_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_edge_sel (cfg_edge_sel),
    .cfg_out_en   (cfg_out_en),
    .level_wr     (level_wr),
    .start        (start),
    .run          (run_w),
    .hit          (hit_w),
    .irq          (irq),
    .pin_out      (pin_out)
);

// File: tb/sim_edge_divider.sv
`timescale 1ns/1ps
module sim_edge_divider;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pin_in = 1'b0;
    logic [1:0]       cfg_edge_sel = 2'b00;
    logic             cfg_start_irq = 1'b0;
    logic             cfg_out_en = 1'b0;
    logic             level_wr = 1'b0;
    logic             level_data = 1'b0;
    logic [CNT_W-1:0] reload_val = '0;
    logic             start = 1'b0;
    logic             stop = 1'b0;
    logic             irq;
    logic             pin_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int  m_valid;
    int  m_n;
    bit  m_run;
    bit  m_pin;

    always #4 clk = ~clk;

    edge_divider #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .pin_in(pin_in), .cfg_edge_sel(cfg_edge_sel),
        .cfg_start_irq(cfg_start_irq), .cfg_out_en(cfg_out_en),
        .level_wr(level_wr), .level_data(level_data), .reload_val(reload_val),
        .start(start), .stop(stop), .irq(irq), .pin_out(pin_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One pin transition; R9 latency: irq/pin sampled after the third posedge.
    task automatic transition(input string req);
        bit rising;
        bit valid;
        bit fire;
        pin_in = ~pin_in;
        rising = pin_in;
        repeat (3) @(posedge clk);
        @(negedge clk);
        case (cfg_edge_sel)
            2'b00:   valid = !rising;
            2'b01:   valid = rising;
            2'b10:   valid = 1'b1;
            default: valid = 1'b0;
        endcase
        fire = 1'b0;
        if (valid && m_run) begin
            m_valid++;
            fire = (m_valid % (m_n + 1)) == 0;
        end
        if (fire && cfg_out_en) m_pin = ~m_pin;
        check(irq == fire, req, irq, fire);
        check(pin_out == m_pin, req, pin_out, m_pin);
    endtask

    task automatic do_start(input string req);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_run = 1'b1;
        m_valid = 0;
        if (cfg_start_irq && cfg_out_en) m_pin = ~m_pin;
        check(irq == cfg_start_irq, req, irq, cfg_start_irq);
        check(pin_out == m_pin, req, pin_out, m_pin);
    endtask

    task automatic do_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        m_run = 1'b0;
    endtask

    task automatic write_level(input bit v);
        level_data = v;
        level_wr = 1'b1;
        @(negedge clk);
        level_wr = 1'b0;
        if (!cfg_out_en) m_pin = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_run = 0; m_pin = 0; m_n = 0; m_valid = 0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(pin_out == 1'b0, "R1 pin_out", pin_out, 0);

        // R2/R3/R4/R5 sweep over edge codes, reload values, start behaviour
        for (int sel = 0; sel < 4; sel++) begin
            for (int ni = 0; ni < 5; ni++) begin
                for (int si = 0; si < 2; si++) begin
                    do_stop();
                    cfg_out_en = 1'b0;
                    write_level(1'b0);
                    cfg_edge_sel = sel[1:0];
                    m_n = (ni == 4) ? 15 : ni;
                    reload_val = m_n[CNT_W-1:0];
                    cfg_start_irq = si[0];
                    cfg_out_en = 1'b1;
                    do_start("R5 start behaviour");
                    for (int t = 0; t < 4 * (m_n + 1) + 2; t++)
                        transition(sel == 3 ? "R3 no-count code" : "R2/R4 interval");
                    idle(2);
                end
            end
        end

        // R6: output disabled, irq still pulses, pin frozen
        do_stop();
        cfg_out_en = 1'b0;
        write_level(1'b1);
        check(pin_out == 1'b1, "R7 level write", pin_out, 1);
        cfg_edge_sel = 2'b10;
        m_n = 1; reload_val = 4'd1;
        cfg_start_irq = 1'b0;
        do_start("R6 start");
        for (int t = 0; t < 8; t++) transition("R6 disabled output");

        // R7: write accepted while running with output disabled, ignored when enabled
        write_level(1'b0);
        check(pin_out == 1'b0, "R7 write while disabled", pin_out, 0);
        cfg_out_en = 1'b1;
        level_data = 1'b1;
        level_wr = 1'b1;
        @(negedge clk);
        level_wr = 1'b0;
        idle(2);
        check(pin_out == 1'b0, "R7 write ignored", pin_out, 0);

        // R8: stop holds, restart reloads and reapplies start rule
        do_stop();
        m_pin = pin_out;
        cfg_edge_sel = 2'b01;
        m_n = 2; reload_val = 4'd2;
        cfg_start_irq = 1'b1;
        do_start("R8 first start");
        for (int t = 0; t < 4; t++) transition("R8 before stop");
        do_stop();
        for (int t = 0; t < 10; t++) transition("R8 stopped");
        do_start("R8 restart");
        for (int t = 0; t < 12; t++) transition("R8 after restart");

        // R9: exact latency - no pulse yet after two clocks
        do_stop();
        cfg_edge_sel = 2'b10;
        m_n = 0; reload_val = 4'd0;
        cfg_start_irq = 1'b0;
        do_start("R9 start");
        pin_in = ~pin_in;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(irq == 1'b0, "R9 too early", irq, 0);
        @(negedge clk);
        check(irq == 1'b1, "R9 third edge", irq, 1);
        @(negedge clk);
        check(irq == 1'b0, "R9 single pulse", irq, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule